// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Fault Reporting

The block sits between the memory fetch port and the instruction decoder. It buffers up to four 16-bit fetched words. Each word carries a tag that records whether the bus returned an access error for it. A tagged word raises nothing while it waits in the queue. The error becomes an exception request only when the decoder actually takes that word, whether as an opword or as an extension word. A change of instruction flow empties the queue. Any faults still waiting in it are then dropped without a trace.

The same block also decides the order in which faults reach the exception logic. The sources are operand read errors, operand write errors (which are reported imprecisely, some time after issue), consumed fetch faults and peripheral interrupts. It presents one request at a time, with a 4-bit fault status and an 8-bit vector number, and holds it until it is acknowledged.

The reporting side is a two-state machine. In state ARB_IDLE, any pending fault causes the transition "grant" to ARB_POST: the highest-priority pending source is latched into the outputs and cleared from the pending set. In state ARB_POST, the transition "release" returns to ARB_IDLE when the acknowledge input is sampled high. With no acknowledge, the machine stays in ARB_POST, and with nothing pending it stays in ARB_IDLE.

Top module: `pfq_fault_ctrl`

## Requirements
- R1: The queue holds at most 4 words and hands them to the decoder in fetch order. `fetch_ready` is low while 4 words are held, and a word offered while `fetch_ready` is low is not stored.
- R2: A word fetched with `fetch_err` high is stored with its tag and raises no exception request for as long as it stays unconsumed.
- R3: `flush` empties the queue on the next edge and discards every stored tag. A word offered in the flush cycle is dropped. A consume in the same cycle as a flush is void and raises no exception.
- R4: Consuming a tagged word (`dec_take` high while `dec_avail` is high) makes `exc_req` rise two rising edges after the consume is sampled, with `exc_fs` = 4'b0100 and `exc_vec` = 8'd2.
- R5: `rd_err` is reported with `exc_fs` = 4'b1100 and `exc_vec` = 8'd2. When it is pending together with a consumed fetch fault, the read error is granted first and the fetch fault follows.
- R6: `wr_err` is reported with `exc_fs` = 4'b1001 if `wr_prot` is high and 4'b1000 otherwise, with `exc_vec` = 8'd2. It ranks below fetch faults and above interrupts, so it may be reported after later activity.
- R7: An interrupt (`irq_req` pulse) is reported with `exc_fs` = 4'b0000 and `exc_vec` equal to the `irq_vec` value sampled with the pulse. It has the lowest priority.
- R8: Only one request is posted at a time. While `exc_req` is high and `exc_ack` is low, `exc_req`, `exc_fs` and `exc_vec` stay unchanged. After an acknowledge, `exc_req` is low for at least one cycle.
- R9: After reset the queue is empty (`dec_avail` low, `fetch_ready` high) and `exc_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch port offers a word |
| fetch_data | input | 16 | Fetched instruction word |
| fetch_err | input | 1 | Bus returned an access error for this word |
| fetch_ready | output | 1 | Queue can accept a word |
| flush | input | 1 | Change of instruction flow |
| dec_avail | output | 1 | Head word is valid |
| dec_word | output | 16 | Head word presented to the decoder |
| dec_take | input | 1 | Decoder consumes the head word |
| rd_err | input | 1 | Operand read error pulse |
| wr_err | input | 1 | Operand write error pulse |
| wr_prot | input | 1 | Write error was a write to protected space |
| irq_req | input | 1 | Interrupt request pulse |
| irq_vec | input | 8 | Peripheral-supplied vector number |
| exc_req | output | 1 | Exception request |
| exc_fs | output | 4 | Fault status of the posted request |
| exc_vec | output | 8 | Vector number of the posted request |
| exc_ack | input | 1 | Exception logic accepts the request |

## Verification
Some pairs of events can fall on the same edge, and the bench forces each pair. A flush can land together with the consume of a tagged word, and then no request may appear. An operand read error can land together with that consume, and then two requests must appear, with status 1100 first and 0100 second. A write error can land together with an interrupt, and then the write is reported before the interrupt. A behavioural reference model, built from queues and pending flags, predicts the queue contents and the request outputs on every clock. Directed checks also confirm the grant order and the two-edge latency.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam logic [3:0] FS_NONE   = 4'b0000;
    localparam logic [3:0] FS_IFETCH = 4'b0100;
    localparam logic [3:0] FS_OPWR   = 4'b1000;
    localparam logic [3:0] FS_WPROT  = 4'b1001;
    localparam logic [3:0] FS_OPRD   = 4'b1100;

    typedef enum logic {
        ARB_IDLE,
        ARB_POST
    } arb_state_e;
endpackage

// File: rtl/pfq_queue.sv
module pfq_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_vld,
    input  logic [W-1:0] push_data,
    input  logic         push_err,
    output logic         push_rdy,
    input  logic         flush,
    input  logic         pop,
    output logic         head_vld,
    output logic [W-1:0] head_data,
    output logic         head_err
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  data_q [DEPTH];
    logic [DEPTH-1:0] err_q;
    logic [DEPTH-1:0] vld_q;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign push_rdy  = ~vld_q[wr_ptr];
    assign head_vld  = vld_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign head_err  = err_q[rd_ptr];
    assign do_push   = push_vld & push_rdy & ~flush;
    assign do_pop    = pop & head_vld & ~flush;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q  <= '0;
            err_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) begin
                data_q[wr_ptr] <= push_data;
                err_q[wr_ptr]  <= push_err;
                vld_q[wr_ptr]  <= 1'b1;
                wr_ptr         <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                vld_q[rd_ptr] <= 1'b0;
                err_q[rd_ptr] <= 1'b0;
                rd_ptr        <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfq_fault_arb.sv
module pfq_fault_arb
    import pfq_pkg::*;
#(
    parameter int VW             = 8,
    parameter logic [VW-1:0] ACC_VEC = 8'd2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_fault,
    input  logic          rd_err,
    input  logic          wr_err,
    input  logic          wr_prot,
    input  logic          irq_req,
    input  logic [VW-1:0] irq_vec,
    input  logic          ack,
    output logic          req,
    output logic [3:0]    fs,
    output logic [VW-1:0] vec
);
    arb_state_e state_q, state_d;
    logic p_rd, p_if, p_wr, p_irq;
    logic [3:0]    p_wr_code;
    logic [VW-1:0] p_irq_vec;
    logic any_pend, grant;
    logic clr_rd, clr_if, clr_wr, clr_irq;
    logic [3:0]    sel_fs;
    logic [VW-1:0] sel_vec;
    logic [3:0]    fs_q;
    logic [VW-1:0] vec_q;

    assign any_pend = p_rd | p_if | p_wr | p_irq;
    assign grant    = (state_q == ARB_IDLE) && any_pend;

    // Fixed priority: read, fetch, write, interrupt
    always_comb begin
        clr_rd  = 1'b0;
        clr_if  = 1'b0;
        clr_wr  = 1'b0;
        clr_irq = 1'b0;
        sel_fs  = FS_NONE;
        sel_vec = ACC_VEC;
        if (p_rd) begin
            clr_rd = grant;
            sel_fs = FS_OPRD;
        end else if (p_if) begin
            clr_if = grant;
            sel_fs = FS_IFETCH;
        end else if (p_wr) begin
            clr_wr = grant;
            sel_fs = p_wr_code;
        end else begin
            clr_irq = grant;
            sel_vec = p_irq_vec;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (any_pend) state_d = ARB_POST;
            ARB_POST: if (ack)      state_d = ARB_IDLE;
            default:                state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= FS_NONE;
            vec_q <= '0;
        end else if (grant) begin
            fs_q  <= sel_fs;
            vec_q <= sel_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_rd      <= 1'b0;
            p_if      <= 1'b0;
            p_wr      <= 1'b0;
            p_irq     <= 1'b0;
            p_wr_code <= FS_OPWR;
            p_irq_vec <= '0;
        end else begin
            p_rd  <= (p_rd  & ~clr_rd)  | rd_err;
            p_if  <= (p_if  & ~clr_if)  | if_fault;
            p_wr  <= (p_wr  & ~clr_wr)  | wr_err;
            p_irq <= (p_irq & ~clr_irq) | irq_req;
            if (wr_err)  p_wr_code <= wr_prot ? FS_WPROT : FS_OPWR;
            if (irq_req) p_irq_vec <= irq_vec;
        end
    end

    assign req = (state_q == ARB_POST);
    assign fs  = fs_q;
    assign vec = vec_q;
endmodule

// File: rtl/pfq_fault_ctrl.sv
module pfq_fault_ctrl #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    parameter int VW    = 8,
    parameter logic [VW-1:0] ACC_VEC = 8'd2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [W-1:0]  fetch_data,
    input  logic          fetch_err,
    output logic          fetch_ready,
    input  logic          flush,
    output logic          dec_avail,
    output logic [W-1:0]  dec_word,
    input  logic          dec_take,
    input  logic          rd_err,
    input  logic          wr_err,
    input  logic          wr_prot,
    input  logic          irq_req,
    input  logic [VW-1:0] irq_vec,
    output logic          exc_req,
    output logic [3:0]    exc_fs,
    output logic [VW-1:0] exc_vec,
    input  logic          exc_ack
);
    logic head_vld, head_err, pop, if_fault;

    // A flush voids any consume in the same cycle
    assign pop      = dec_take & head_vld & ~flush;
    assign if_fault = pop & head_err;

    pfq_queue #(.DEPTH(DEPTH), .W(W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_vld  (fetch_valid),
        .push_data (fetch_data),
        .push_err  (fetch_err),
        .push_rdy  (fetch_ready),
        .flush     (flush),
        .pop       (pop),
        .head_vld  (head_vld),
        .head_data (dec_word),
        .head_err  (head_err)
    );

    pfq_fault_arb #(.VW(VW), .ACC_VEC(ACC_VEC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .if_fault (if_fault),
        .rd_err   (rd_err),
        .wr_err   (wr_err),
        .wr_prot  (wr_prot),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .ack      (exc_ack),
        .req      (exc_req),
        .fs       (exc_fs),
        .vec      (exc_vec)
    );

    assign dec_avail = head_vld;
endmodule

// File: rtl/pfq_fault_chk.sv
module pfq_fault_chk #(
    parameter int W  = 16,
    parameter int VW = 8,
    parameter logic [VW-1:0] ACC_VEC = 8'd2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_valid,
    input logic [W-1:0]  fetch_data,
    input logic          fetch_err,
    input logic          fetch_ready,
    input logic          flush,
    input logic          dec_avail,
    input logic [W-1:0]  dec_word,
    input logic          dec_take,
    input logic          rd_err,
    input logic          wr_err,
    input logic          wr_prot,
    input logic          irq_req,
    input logic [VW-1:0] irq_vec,
    input logic          exc_req,
    input logic [3:0]    exc_fs,
    input logic [VW-1:0] exc_vec,
    input logic          exc_ack
);
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && !exc_ack |=> exc_req && $stable(exc_fs) && $stable(exc_vec));

    a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && exc_ack |=> !exc_req);

    a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dec_avail && fetch_ready);

    a_r1_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ready |-> dec_avail);

    a_r5_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_fs == 4'b0000 || exc_fs == 4'b0100 || exc_fs == 4'b1000 ||
                     exc_fs == 4'b1001 || exc_fs == 4'b1100));

    a_r4_access_vector: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && exc_fs != 4'b0000 |-> exc_vec == ACC_VEC);
endmodule

bind pfq_fault_ctrl pfq_fault_chk #(.W(W), .VW(VW), .ACC_VEC(ACC_VEC)) u_chk (.*);

// File: tb/sim_pfq_fault_ctrl.sv
`timescale 1ns/1ps
module sim_pfq_fault_ctrl;
    localparam int DEPTH = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_valid = 0, fetch_err = 0, flush = 0, dec_take = 0;
    logic [15:0] fetch_data = '0;
    logic rd_err = 0, wr_err = 0, wr_prot = 0, irq_req = 0, exc_ack = 0;
    logic [7:0] irq_vec = '0;
    logic fetch_ready, dec_avail, exc_req;
    logic [15:0] dec_word;
    logic [3:0] exc_fs;
    logic [7:0] exc_vec;

    always #2.5 clk = ~clk;

    pfq_fault_ctrl u0 (.*);

    int vecs = 0, miss = 0;
    bit done = 0;

    // Reference model
    logic [15:0] m_dat[$];
    bit          m_err[$];
    bit m_req, p_rd, p_if, p_wr, p_irq;
    logic [3:0] m_fs, p_wcode;
    logic [7:0] m_vec, p_ivec;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dat.delete(); m_err.delete();
            m_req = 0; p_rd = 0; p_if = 0; p_wr = 0; p_irq = 0;
            m_fs = 0; m_vec = 0; p_wcode = 4'b1000; p_ivec = 0;
        end else begin
            bit avail, ready, cons, ff;
            avail = m_dat.size() > 0;
            ready = m_dat.size() < DEPTH;
            cons  = dec_take && avail && !flush;
            ff    = cons && m_err[0];
            if (!m_req) begin
                if (p_rd)       begin m_fs = 4'b1100; m_vec = 8'd2; p_rd = 0; m_req = 1; end
                else if (p_if)  begin m_fs = 4'b0100; m_vec = 8'd2; p_if = 0; m_req = 1; end
                else if (p_wr)  begin m_fs = p_wcode; m_vec = 8'd2; p_wr = 0; m_req = 1; end
                else if (p_irq) begin m_fs = 4'b0000; m_vec = p_ivec; p_irq = 0; m_req = 1; end
            end else if (exc_ack) m_req = 0;
            if (rd_err) p_rd = 1;
            if (ff) p_if = 1;
            if (wr_err) begin p_wr = 1; p_wcode = wr_prot ? 4'b1001 : 4'b1000; end
            if (irq_req) begin p_irq = 1; p_ivec = irq_vec; end
            if (flush) begin m_dat.delete(); m_err.delete(); end
            else begin
                if (cons) begin void'(m_dat.pop_front()); void'(m_err.pop_front()); end
                if (fetch_valid && ready) begin m_dat.push_back(fetch_data); m_err.push_back(fetch_err); end
            end
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(fetch_ready == (m_dat.size() < DEPTH), "R1", "fetch_ready", fetch_ready, m_dat.size() < DEPTH);
            chk(dec_avail == (m_dat.size() > 0), "R3", "dec_avail", dec_avail, m_dat.size() > 0);
            if (m_dat.size() > 0) chk(dec_word == m_dat[0], "R1", "dec_word", dec_word, m_dat[0]);
            chk(exc_req == m_req, "R4", "exc_req", exc_req, m_req);
            if (m_req) begin
                chk(exc_fs == m_fs, "R5", "exc_fs", exc_fs, m_fs);
                chk(exc_vec == m_vec, "R7", "exc_vec", exc_vec, m_vec);
            end
        end
    end

    task automatic push_word(logic [15:0] d, bit e);
        fetch_valid = 1; fetch_data = d; fetch_err = e;
        @(negedge clk);
        fetch_valid = 0; fetch_err = 0;
    endtask

    task automatic do_ack();
        exc_ack = 1;
        @(negedge clk);
        exc_ack = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(dec_avail == 0, "R9", "reset dec_avail", dec_avail, 0);
        chk(fetch_ready == 1, "R9", "reset fetch_ready", fetch_ready, 1);
        chk(exc_req == 0, "R9", "reset exc_req", exc_req, 0);

        // R1: fill beyond depth, then drain in order
        for (int i = 0; i < 5; i++) push_word(16'hA000 + 16'(i), 0);
        chk(fetch_ready == 0, "R1", "full ready", fetch_ready, 0);
        for (int i = 0; i < 4; i++) begin
            chk(dec_word == 16'hA000 + 16'(i), "R1", "order", dec_word, 16'hA000 + i);
            dec_take = 1; @(negedge clk); dec_take = 0;
        end
        chk(dec_avail == 0, "R1", "word offered while full dropped", dec_avail, 0);

        // R2: tagged word waits silently
        push_word(16'hBEEF, 1);
        repeat (4) @(negedge clk);
        chk(exc_req == 0, "R2", "no request at fetch", exc_req, 0);
        chk(dec_avail == 1, "R2", "tagged word stored", dec_avail, 1);

        // R4: consume it
        dec_take = 1; @(negedge clk); dec_take = 0;
        chk(exc_req == 0, "R4", "one edge after consume", exc_req, 0);
        @(negedge clk);
        chk(exc_req == 1, "R4", "req after two edges", exc_req, 1);
        chk(exc_fs == 4'b0100, "R4", "fetch status", exc_fs, 4'b0100);
        chk(exc_vec == 8'd2, "R4", "access vector", exc_vec, 2);
        rd_err = 1; @(negedge clk); rd_err = 0;   // arrives while posted
        repeat (2) @(negedge clk);
        chk(exc_fs == 4'b0100 && exc_req, "R8", "held until ack", exc_fs, 4'b0100);
        do_ack();
        chk(exc_req == 0, "R8", "gap after ack", exc_req, 0);
        @(negedge clk);
        chk(exc_fs == 4'b1100, "R5", "queued read error", exc_fs, 4'b1100);
        do_ack();
        @(negedge clk);

        // R3: flush wins over same-cycle consume, incoming word dropped
        push_word(16'hC001, 1);
        dec_take = 1; flush = 1; fetch_valid = 1; fetch_data = 16'hC002;
        @(negedge clk);
        dec_take = 0; flush = 0; fetch_valid = 0;
        chk(dec_avail == 0, "R3", "flush empties", dec_avail, 0);
        repeat (3) @(negedge clk);
        chk(exc_req == 0, "R3", "no request after flush", exc_req, 0);
        // R3: flushed tag is not reported later
        push_word(16'hC003, 1);
        flush = 1; @(negedge clk); flush = 0;
        push_word(16'hC004, 0);
        dec_take = 1; @(negedge clk); dec_take = 0;
        repeat (2) @(negedge clk);
        chk(exc_req == 0, "R3", "discarded tag", exc_req, 0);

        // R5: read error with fetch fault same cycle
        push_word(16'hD001, 1);
        dec_take = 1; rd_err = 1; @(negedge clk); dec_take = 0; rd_err = 0;
        @(negedge clk);
        chk(exc_fs == 4'b1100 && exc_req, "R5", "read first", exc_fs, 4'b1100);
        do_ack();
        @(negedge clk);
        chk(exc_fs == 4'b0100 && exc_req, "R5", "fetch second", exc_fs, 4'b0100);
        do_ack();
        @(negedge clk);

        // R6: protected and plain write errors
        wr_err = 1; wr_prot = 1; @(negedge clk); wr_err = 0; wr_prot = 0;
        @(negedge clk);
        chk(exc_fs == 4'b1001, "R6", "protected write", exc_fs, 4'b1001);
        do_ack();
        @(negedge clk);
        // R6/R7: write and interrupt together
        wr_err = 1; irq_req = 1; irq_vec = 8'h47;
        @(negedge clk); wr_err = 0; irq_req = 0; irq_vec = 8'h00;
        @(negedge clk);
        chk(exc_fs == 4'b1000, "R6", "plain write first", exc_fs, 4'b1000);
        chk(exc_vec == 8'd2, "R6", "write vector", exc_vec, 2);
        do_ack();
        @(negedge clk);
        chk(exc_fs == 4'b0000 && exc_req, "R7", "interrupt status", exc_fs, 0);
        chk(exc_vec == 8'h47, "R7", "interrupt vector", exc_vec, 8'h47);
        do_ack();
        repeat (2) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            miss++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end
endmodule